// File: doc/BRIEF.md
# Interrupt Controller Setup Word Sequencer

This block is the register front end of an interrupt controller. It watches a byte-wide write port with two addresses, command and data, and turns the writes into the configuration that the priority logic uses. Writing a command byte with bit 4 set opens a setup sequence. The data writes that follow are then taken in a fixed order: first the vector base, then the cascade wiring byte, then the environment byte. Flags in the opening command byte decide whether the cascade byte and the environment byte are expected at all.

Once the last expected word has been taken, the block raises a ready flag. Data writes from then on load the interrupt mask. A command write with bit 4 clear is a normal operational command. It is passed on as a one-cycle strobe carrying the byte, and it does not disturb a sequence that is still open. The vector base can only change through a new setup sequence. Opening a sequence clears the mask, requests a clear of the in-service state, and zeroes the cascade and environment fields before the new words arrive.

Top module: `irq_init_seq`

## Requirements
- R1: After reset, ready is 0 and every configuration output, the mask, svc_clear and cmd_strobe are 0.
- R2: A command write (wr_addr=0) with bit 4 set opens a sequence. In the cycle after the write, ready is 0, the mask is 0 and svc_clear pulses for one cycle. From the command byte the block takes need_env from bit 0, single mode from bit 1, interval4 from bit 2 and level mode from bit 3. The cascade byte and all environment fields are 0. Bits 7:5 are ignored.
- R3: The first data write (wr_addr=1) after the opening command sets vec_base to the written byte with bits 2:0 forced to 0.
- R4: When single mode is clear, the second data write is taken as the cascade byte. When single mode is set, no cascade byte is expected and casc_word stays 0.
- R5: When need_env is set, the last data write of the sequence is the environment byte. Its fields are decoded as follows: bit 0 gives cpu16_mode, bit 1 gives auto_eoi and bit 4 gives sfn_mode. Bits 3:2 give the buffering: 10 sets buffered=1 with buf_master=0, 11 sets buffered=1 with buf_master=1, and 0x sets both to 0.
- R6: When need_env is clear, no environment byte is expected and all environment fields stay 0.
- R7: ready rises in the cycle after the last expected word has been taken. Data writes made while ready is set, or before any sequence has run, load the mask and leave vec_base and every other configuration field unchanged.
- R8: Data writes taken as sequence words do not change the mask.
- R9: A command write with bit 4 clear produces cmd_strobe=1 and cmd_byte equal to the written byte in the next cycle, for one cycle. It leaves the sequence position and ready unchanged.
- R10: A command write with bit 4 set while a sequence is open restarts it, so the next data write is again taken as the vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = command address, 1 = data address |
| wr_data | input | 8 | Write byte |
| ready | output | 1 | Setup sequence complete |
| vec_base | output | 8 | Vector base, low 3 bits zero |
| single_mode | output | 1 | No cascade partner |
| level_mode | output | 1 | Level-triggered inputs |
| interval4 | output | 1 | Call interval of 4 |
| casc_word | output | 8 | Cascade wiring byte |
| cpu16_mode | output | 1 | 16-bit processor mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| buffered | output | 1 | Buffered bus mode |
| buf_master | output | 1 | Buffered role is master |
| sfn_mode | output | 1 | Special fully nested mode |
| mask | output | 8 | Interrupt mask |
| svc_clear | output | 1 | One-cycle request to clear in-service state |
| cmd_strobe | output | 1 | One-cycle strobe for a normal command |
| cmd_byte | output | 8 | Byte of the last normal command |

## Verification
The bench opens a sequence with each of the 16 combinations of the command byte's low flag bits. This separates the four word-count paths (base only, base+cascade, base+environment, all three) and shows that each flag lands on its own output. All 32 environment bytes are swept, which tells apart the buffered-slave, buffered-master and unbuffered codes along with the single-bit fields. Normal commands are placed in the middle of sequences, and restarts are issued mid-sequence. These confirm that a normal command leaves the word position alone and that a restart moves it back to the base word. Mask writes after completion check that only the mask moves.

// File: rtl/irq_init_pkg.sv
package irq_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_ENV,
    ST_READY
  } seq_state_e;

  typedef struct packed {
    logic level;
    logic interval4;
    logic single;
    logic need_env;
  } open_flags_t;

  typedef struct packed {
    logic sfn;
    logic buf_master;
    logic buffered;
    logic auto_eoi;
    logic cpu16;
  } env_fields_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode #(
  parameter int DATA_W    = 8,
  parameter int START_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              start,
  output logic              data_wr,
  output logic              svc_clear,
  output logic              cmd_strobe,
  output logic [DATA_W-1:0] cmd_byte
);

  logic              op_wr;
  logic              svc_d, strobe_d;
  logic [DATA_W-1:0] byte_d;

  always_comb begin
    start   = wr_en && !wr_addr && wr_data[START_BIT];
    op_wr   = wr_en && !wr_addr && !wr_data[START_BIT];
    data_wr = wr_en && wr_addr;
  end

  always_comb begin
    svc_d    = start;
    strobe_d = op_wr;
    byte_d   = op_wr ? wr_data : cmd_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_clear  <= 1'b0;
      cmd_strobe <= 1'b0;
      cmd_byte   <= '0;
    end else begin
      svc_clear  <= svc_d;
      cmd_strobe <= strobe_d;
      cmd_byte   <= byte_d;
    end
  end

  // R9: a normal command is presented with its byte one cycle later
  a_r9_cmd_strobe : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && !wr_data[START_BIT]) |=> (cmd_strobe && cmd_byte == $past(wr_data)));

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_init_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic data_wr,
  input  logic need_env,
  input  logic single,
  output logic take_base,
  output logic take_casc,
  output logic take_env,
  output logic mask_wr,
  output logic ready
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    take_base = 1'b0;
    take_casc = 1'b0;
    take_env  = 1'b0;
    mask_wr   = 1'b0;
    if (start) begin
      state_d = ST_BASE;
    end else if (data_wr) begin
      unique case (state_q)
        ST_BASE: begin
          take_base = 1'b1;
          if (!single)      state_d = ST_CASC;
          else if (need_env) state_d = ST_ENV;
          else               state_d = ST_READY;
        end
        ST_CASC: begin
          take_casc = 1'b1;
          state_d   = need_env ? ST_ENV : ST_READY;
        end
        ST_ENV: begin
          take_env = 1'b1;
          state_d  = ST_READY;
        end
        ST_IDLE, ST_READY: mask_wr = 1'b1;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb ready = (state_q == ST_READY);

  // R7: ready only rises right after a data word was taken
  a_r7_ready_rise : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(data_wr));

  // R10: an opening command always returns to the base word
  a_r10_restart : assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state_q == ST_BASE));

  // R8: at most one kind of word is consumed per write
  a_r8_one_take : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_base, take_casc, take_env, mask_wr}));

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_init_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int VEC_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take_base,
  input  logic              take_casc,
  input  logic              take_env,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wr_data,
  output open_flags_t       flags,
  output logic [DATA_W-1:0] vec_base,
  output logic [DATA_W-1:0] casc_word,
  output env_fields_t       env,
  output logic [DATA_W-1:0] mask
);

  localparam int BASE_W = DATA_W - VEC_LSB;

  open_flags_t       flags_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [DATA_W-1:0] casc_d, mask_d;
  env_fields_t       env_d;

  always_comb begin
    flags_d = flags;
    base_d  = base_q;
    casc_d  = casc_word;
    env_d   = env;
    mask_d  = mask;
    if (start) begin
      flags_d.need_env  = wr_data[0];
      flags_d.single    = wr_data[1];
      flags_d.interval4 = wr_data[2];
      flags_d.level     = wr_data[3];
      casc_d            = '0;
      env_d             = '0;
      mask_d            = '0;
    end
    if (take_base) base_d = wr_data[DATA_W-1:VEC_LSB];
    if (take_casc) casc_d = wr_data;
    if (take_env) begin
      env_d.cpu16      = wr_data[0];
      env_d.auto_eoi   = wr_data[1];
      env_d.buffered   = wr_data[3];
      env_d.buf_master = wr_data[3] & wr_data[2];
      env_d.sfn        = wr_data[4];
    end
    if (mask_wr) mask_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      base_q <= '0;
      casc_word <= '0;
      env    <= '0;
      mask   <= '0;
    end else begin
      flags  <= flags_d;
      base_q <= base_d;
      casc_word <= casc_d;
      env    <= env_d;
      mask   <= mask_d;
    end
  end

  always_comb vec_base = {base_q, {VEC_LSB{1'b0}}};

  // R2: opening a sequence clears mask, cascade byte and environment fields
  a_r2_open_clear : assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mask == '0 && casc_word == '0 && env == '0));

  // R8: the mask only moves on a mask write or an opening command
  a_r8_mask_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_wr && !start) |=> $stable(mask));

  // R7: the vector base only moves when the base word is taken
  a_r7_base_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !take_base |=> $stable(vec_base));

  // R5: buffered master implies buffered
  a_r5_buf_code : assert property (@(posedge clk) disable iff (!rst_n)
    env.buf_master |-> env.buffered);

endmodule

// File: rtl/irq_init_seq.sv
module irq_init_seq
  import irq_init_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int VEC_LSB   = 3,
  parameter int START_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ready,
  output logic [DATA_W-1:0] vec_base,
  output logic              single_mode,
  output logic              level_mode,
  output logic              interval4,
  output logic [DATA_W-1:0] casc_word,
  output logic              cpu16_mode,
  output logic              auto_eoi,
  output logic              buffered,
  output logic              buf_master,
  output logic              sfn_mode,
  output logic [DATA_W-1:0] mask,
  output logic              svc_clear,
  output logic              cmd_strobe,
  output logic [DATA_W-1:0] cmd_byte
);

  logic [1:0]  rst_sync;
  logic        rst_ni;
  logic        start, data_wr;
  logic        take_base, take_casc, take_env, mask_wr;
  open_flags_t flags;
  env_fields_t env;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  always_comb rst_ni = rst_sync[1];

  irq_cmd_decode #(.DATA_W(DATA_W), .START_BIT(START_BIT)) u_dec (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .data_wr(data_wr), .svc_clear(svc_clear),
    .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte)
  );

  irq_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_ni), .start(start), .data_wr(data_wr),
    .need_env(flags.need_env), .single(flags.single),
    .take_base(take_base), .take_casc(take_casc), .take_env(take_env),
    .mask_wr(mask_wr), .ready(ready)
  );

  irq_cfg_regs #(.DATA_W(DATA_W), .VEC_LSB(VEC_LSB)) u_cfg (
    .clk(clk), .rst_n(rst_ni), .start(start), .take_base(take_base),
    .take_casc(take_casc), .take_env(take_env), .mask_wr(mask_wr),
    .wr_data(wr_data), .flags(flags), .vec_base(vec_base),
    .casc_word(casc_word), .env(env), .mask(mask)
  );

  always_comb begin
    single_mode = flags.single;
    level_mode  = flags.level;
    interval4   = flags.interval4;
    cpu16_mode  = env.cpu16;
    auto_eoi    = env.auto_eoi;
    buffered    = env.buffered;
    buf_master  = env.buf_master;
    sfn_mode    = env.sfn;
  end

  // R9: a normal command leaves ready unchanged
  a_r9_ready_kept : assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_addr && !wr_data[START_BIT]) |=> $stable(ready));

  // R2: an opening command drops ready
  a_r2_ready_drop : assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_addr && wr_data[START_BIT]) |=> !ready);

endmodule

// File: tb/sim_irq_init_seq.sv
module sim_irq_init_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ready, single_mode, level_mode, interval4;
  logic       cpu16_mode, auto_eoi, buffered, buf_master, sfn_mode;
  logic       svc_clear, cmd_strobe;
  logic [7:0] vec_base, casc_word, mask, cmd_byte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_init_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ready(ready), .vec_base(vec_base), .single_mode(single_mode),
    .level_mode(level_mode), .interval4(interval4), .casc_word(casc_word),
    .cpu16_mode(cpu16_mode), .auto_eoi(auto_eoi), .buffered(buffered),
    .buf_master(buf_master), .sfn_mode(sfn_mode), .mask(mask),
    .svc_clear(svc_clear), .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [4:0] env_exp(logic [7:0] e);
    return {e[4], e[3] & e[2], e[3], e[1], e[0]};
  endfunction

  task automatic chk_env(string tag, logic [4:0] x);
    chk(tag, {sfn_mode, buf_master, buffered, auto_eoi, cpu16_mode}, x);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, c, e, m, exp_base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ready", ready, 0);
    chk("R1 fields", {vec_base, casc_word, mask, single_mode, level_mode, interval4}, 0);
    chk_env("R1 env", 5'd0);
    chk("R1 pulses", {svc_clear, cmd_strobe}, 0);

    // R7 mask loads before any sequence
    wr(1'b1, 8'hA5);
    chk("R7 mask pre-init", mask, 8'hA5);

    // Sweep of all opening flag combinations
    for (int n = 0; n < 16; n++) begin
      logic ne, sg;
      ne = n[0]; sg = n[1];
      wr(1'b1, 8'h3C ^ 8'(n));
      wr(1'b0, 8'h10 | 8'(n) | 8'(n << 5));
      chk("R2 ready low", ready, 0);
      chk("R2 mask clear", mask, 0);
      chk("R2 svc_clear", svc_clear, 1);
      chk("R2 flags", {level_mode, interval4, single_mode}, {n[3], n[2], n[1]});
      chk("R2 casc zero", casc_word, 0);
      chk_env("R2 env zero", 5'd0);
      @(negedge clk);
      chk("R2 svc_clear one cycle", svc_clear, 0);
      b = 8'(n * 29 + 7);
      exp_base = b & 8'hF8;
      wr(1'b1, b);
      chk("R3 base", vec_base, exp_base);
      chk("R8 mask kept base", mask, 0);
      if (n % 2 == 1) begin
        wr(1'b0, 8'h20 + 8'(n));
        chk("R9 strobe", cmd_strobe, 1);
        chk("R9 byte", cmd_byte, 8'h20 + n);
        @(negedge clk);
        chk("R9 strobe one cycle", cmd_strobe, 0);
      end
      c = ~b;
      if (!sg) begin
        chk("R7 not ready before casc", ready, 0);
        wr(1'b1, c);
        chk("R4 casc taken", casc_word, c);
      end else begin
        chk("R4 casc skipped", casc_word, 0);
      end
      e = 8'(n * 3 + 1);
      if (ne) begin
        chk("R7 not ready before env", ready, 0);
        wr(1'b1, e);
        chk_env("R5 env", env_exp(e));
      end else begin
        chk_env("R6 env skipped", 5'd0);
      end
      chk("R7 ready", ready, 1);
      chk("R8 mask kept seq", mask, 0);
      m = 8'(n * 17) ^ 8'hFF;
      wr(1'b1, m);
      chk("R7 mask load", mask, m);
      chk("R7 base unchanged", vec_base, exp_base);
      chk("R7 casc unchanged", casc_word, sg ? 0 : c);
      chk_env("R7 env unchanged", ne ? env_exp(e) : 5'd0);
    end

    // R5 full environment byte sweep
    for (int k = 0; k < 32; k++) begin
      wr(1'b0, 8'h11);
      wr(1'b1, 8'h40);
      wr(1'b1, 8'h04);
      wr(1'b1, 8'(k) | 8'hE0);
      chk_env("R5 env sweep", env_exp(8'(k)));
      chk("R5 ready", ready, 1);
    end

    // R10 restart mid-sequence
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h88);
    chk("R3 base before restart", vec_base, 8'h88);
    wr(1'b0, 8'h13);
    chk("R10 ready low", ready, 0);
    chk("R10 single", single_mode, 1);
    wr(1'b1, 8'hC9);
    chk("R10 base retaken", vec_base, 8'hC8);
    chk("R10 casc skipped", casc_word, 0);
    chk("R10 ready waits env", ready, 0);
    wr(1'b1, 8'h0C);
    chk_env("R10 env", 5'b01100);
    chk("R10 ready", ready, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule